// File: doc/BRIEF.md
# Delayed-Branch Next-PC Sequencer

This block resolves the fetch-address pair for one decoded control-transfer instruction per cycle. The machine it serves uses a delay slot. The instruction at `pc_i` is followed by the one at `npc_i`, and a redirect takes effect only after that slot. The caller supplies the instruction class, the low 30 bits of the instruction word, the current PC and delay-slot address, a predicted-taken bit and two register operands.

From these inputs the block forms the branch or jump target and decides three things: whether the transfer is taken, whether the delay slot is cancelled, and whether a link register is written. The results are registered and appear one cycle after the request. The fetch unit loads `npc_o`/`nnpc_o` as its new address pair, and the register file takes the link write.

Several displacement formats are handled, one of them split across two fields of the word. The annul bit cancels the delay slot in three different ways: for branch-always, for branch-never, and for a conditional branch predicted not taken. Evaluating conditions and predicting branches are done elsewhere.

Top module: `nps_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `valid_o`, `taken_o`, `annul_o` and `link_we_o` are 0.
- R2: When `valid_i` is high, the outputs show the result for the request one clock later. For class 0 (no transfer): `npc_o`=`npc_i`, `nnpc_o`=`npc_i`+4, and `taken_o`, `annul_o`, `link_we_o` are 0.
- R3: For class 1 (call), the target is `pc_i` plus `inst_i[29:0]`, sign-extended and shifted left 2. The transfer is taken with `nnpc_o`=target and `npc_o`=`npc_i`. The link writes `pc_i` to register 15.
- R4: For classes 2 to 5, `target_o` is `pc_i` plus a displacement shifted left 2. With `pform_i`=0 the displacement is `inst_i[21:0]` sign-extended; with `pform_i`=1 it is `inst_i[18:0]` sign-extended.
- R5: For class 6 (branch on register), the offset is `inst_i[21:20]` sign-extended and shifted left 16, ORed with `inst_i[13:0]` shifted left 2, and it is added to `pc_i`.
- R6: For class 2 (always), the transfer is taken with `nnpc_o`=target. If `inst_i[29]` (annul) is 1, then `npc_o`=target, `nnpc_o`=target+4 and `annul_o`=1.
- R7: For class 3 (never), the transfer is not taken. With annul, `npc_o`=`npc_i`+4, `nnpc_o`=`npc_i`+8 and `annul_o`=1; without annul, the outputs are as in R2.
- R8: For classes 4 and 5 (conditional), when `pred_taken_i`=1 the transfer is taken with `nnpc_o`=target, `npc_o`=`npc_i` and `annul_o`=0, whatever the annul bit.
- R9: For classes 4 and 5, when `pred_taken_i`=0 and annul is set, the slot is skipped as in R7. With annul clear, the outputs are as in R2.
- R10: For class 6, the annul bit has no effect. If predicted taken, the transfer is taken with `nnpc_o`=target; otherwise the outputs are as in R2.
- R11: For class 7 (jump-and-link), the target is `rs1_val_i` plus either `rs2_val_i` or, when `inst_i[13]`=1, `inst_i[12:0]` sign-extended. The transfer is always taken with `nnpc_o`=target. The link writes `pc_i` to register `inst_i[29:25]`.
- R12: All address sums are 64-bit and wrap modulo 2^64. When `valid_i` is low, `valid_o` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request present |
| kind_i | input | 3 | Instruction class 0..7 |
| inst_i | input | 30 | Low 30 bits of the instruction word |
| pform_i | input | 1 | Branch uses the 19-bit displacement |
| pred_taken_i | input | 1 | Predicted-taken bit |
| pc_i | input | 64 | Address of the instruction |
| npc_i | input | 64 | Address of its delay slot |
| rs1_val_i | input | 64 | First register operand |
| rs2_val_i | input | 64 | Second register operand |
| valid_o | output | 1 | Result present |
| npc_o | output | 64 | New next PC |
| nnpc_o | output | 64 | New next-next PC |
| taken_o | output | 1 | Transfer taken |
| annul_o | output | 1 | Delay slot cancelled |
| target_o | output | 64 | Computed target |
| link_we_o | output | 1 | Link register write |
| link_idx_o | output | 5 | Link register number |
| link_data_o | output | 64 | Link value |

## Verification
Every result, including the computed target and the link write, is due exactly one rising edge after the request is presented. The bench drives a request on a falling edge, lets one rising edge pass, and compares every output on the following falling edge. Each comparison is therefore made against the request just issued and never a later one. Clearing `valid_i` is checked the same way, by reading `valid_o` one edge later.

// File: rtl/nps_pkg.sv
package nps_pkg;

    localparam int unsigned ADDR_W   = 64;
    localparam int unsigned WORD_W   = 30;
    localparam int unsigned REG_IDXW = 5;
    localparam int unsigned LINK_REG = 15;

    // field positions inside the instruction word
    localparam int unsigned ANNUL_BIT = 29;
    localparam int unsigned IMM_BIT   = 13;

    typedef enum logic [2:0] {
        CT_NONE   = 3'd0,
        CT_CALL   = 3'd1,
        CT_ALWAYS = 3'd2,
        CT_NEVER  = 3'd3,
        CT_ICOND  = 3'd4,
        CT_FCOND  = 3'd5,
        CT_REGBR  = 3'd6,
        CT_JMPL   = 3'd7
    } ct_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] npc;
        logic [ADDR_W-1:0] nnpc;
        logic              taken;
        logic              annul;
    } seq_res_t;

    typedef struct packed {
        logic                we;
        logic [REG_IDXW-1:0] idx;
        logic [ADDR_W-1:0]   data;
    } link_t;

    function automatic logic is_cond(ct_kind_e k);
        return (k == CT_ICOND) || (k == CT_FCOND);
    endfunction

endpackage

// File: rtl/nps_target.sv
module nps_target
    import nps_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  ct_kind_e           kind,
    input  logic [WORD_W-1:0]  inst,
    input  logic               pform,
    input  logic [AW-1:0]      pc,
    input  logic [AW-1:0]      rs1,
    input  logic [AW-1:0]      rs2,
    output logic [AW-1:0]      target
);
    localparam int unsigned CALL_W = 30;
    localparam int unsigned D22_W  = 22;
    localparam int unsigned D19_W  = 19;
    localparam int unsigned HI_W   = 2;
    localparam int unsigned LO_W   = 14;
    localparam int unsigned SIMM_W = 13;

    logic [AW-1:0] off_call, off22, off19, off_reg, simm, opnd2;
    logic [AW-1:0] base, addend;

    always_comb begin
        off_call = {{(AW-CALL_W-2){inst[CALL_W-1]}}, inst[CALL_W-1:0], 2'b00};
        off22    = {{(AW-D22_W-2){inst[D22_W-1]}}, inst[D22_W-1:0], 2'b00};
        off19    = {{(AW-D19_W-2){inst[D19_W-1]}}, inst[D19_W-1:0], 2'b00};
        off_reg  = {{(AW-HI_W-16){inst[21]}}, inst[21:20], 16'h0000}
                 | {{(AW-LO_W-2){1'b0}}, inst[LO_W-1:0], 2'b00};
        simm     = {{(AW-SIMM_W){inst[SIMM_W-1]}}, inst[SIMM_W-1:0]};
        opnd2    = inst[IMM_BIT] ? simm : rs2;
    end

    always_comb begin
        base = pc;
        unique case (kind)
            CT_CALL:  addend = off_call;
            CT_REGBR: addend = off_reg;
            CT_JMPL: begin
                base   = rs1;
                addend = opnd2;
            end
            default:  addend = pform ? off19 : off22;
        endcase
        target = base + addend;
    end
endmodule

// File: rtl/nps_redirect.sv
module nps_redirect
    import nps_pkg::*;
#(
    parameter int unsigned AW   = ADDR_W,
    parameter int unsigned STEP = 4
) (
    input  ct_kind_e      kind,
    input  logic          annul_bit,
    input  logic          pred_taken,
    input  logic [AW-1:0] npc,
    input  logic [AW-1:0] target,
    output seq_res_t      res
);
    localparam logic [AW-1:0] INC = AW'(STEP);

    logic [AW-1:0] after_slot;
    logic          skip_slot;
    logic          redirect;

    always_comb begin
        after_slot = npc + INC;
        redirect   = 1'b0;
        skip_slot  = 1'b0;
        unique case (kind)
            CT_CALL, CT_JMPL, CT_ALWAYS: redirect = 1'b1;
            CT_NEVER:                    skip_slot = annul_bit;
            CT_ICOND, CT_FCOND: begin
                redirect  = pred_taken;
                skip_slot = !pred_taken && annul_bit;
            end
            CT_REGBR:                    redirect = pred_taken;
            default: ;
        endcase
    end

    always_comb begin
        res.npc   = npc;
        res.nnpc  = after_slot;
        res.taken = redirect;
        res.annul = 1'b0;
        if (kind == CT_ALWAYS && annul_bit) begin
            res.npc   = target;
            res.nnpc  = target + INC;
            res.annul = 1'b1;
        end else if (redirect) begin
            res.nnpc  = target;
        end else if (skip_slot) begin
            res.npc   = after_slot;
            res.nnpc  = after_slot + INC;
            res.annul = 1'b1;
        end
    end
endmodule

// File: rtl/nps_seq.sv
module nps_seq
    import nps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [2:0]          kind_i,
    input  logic [WORD_W-1:0]   inst_i,
    input  logic                pform_i,
    input  logic                pred_taken_i,
    input  logic [ADDR_W-1:0]   pc_i,
    input  logic [ADDR_W-1:0]   npc_i,
    input  logic [ADDR_W-1:0]   rs1_val_i,
    input  logic [ADDR_W-1:0]   rs2_val_i,
    output logic                valid_o,
    output logic [ADDR_W-1:0]   npc_o,
    output logic [ADDR_W-1:0]   nnpc_o,
    output logic                taken_o,
    output logic                annul_o,
    output logic [ADDR_W-1:0]   target_o,
    output logic                link_we_o,
    output logic [REG_IDXW-1:0] link_idx_o,
    output logic [ADDR_W-1:0]   link_data_o
);
    ct_kind_e          kind;
    logic [ADDR_W-1:0] target;
    seq_res_t          res_d, res_q;
    link_t             link_d, link_q;
    logic [ADDR_W-1:0] target_q;
    logic              valid_q;

    assign kind = ct_kind_e'(kind_i);

    nps_target #(.AW(ADDR_W)) i_target (
        .kind   (kind),
        .inst   (inst_i),
        .pform  (pform_i),
        .pc     (pc_i),
        .rs1    (rs1_val_i),
        .rs2    (rs2_val_i),
        .target (target)
    );

    nps_redirect #(.AW(ADDR_W), .STEP(4)) i_redirect (
        .kind       (kind),
        .annul_bit  (inst_i[ANNUL_BIT]),
        .pred_taken (pred_taken_i),
        .npc        (npc_i),
        .target     (target),
        .res        (res_d)
    );

    always_comb begin
        link_d.we   = (kind == CT_CALL) || (kind == CT_JMPL);
        link_d.idx  = (kind == CT_CALL) ? REG_IDXW'(LINK_REG) : inst_i[29:25];
        link_d.data = pc_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            res_q    <= '0;
            link_q   <= '0;
            target_q <= '0;
        end else begin
            valid_q <= valid_i;
            if (valid_i) begin
                res_q    <= res_d;
                link_q   <= link_d;
                target_q <= target;
            end else begin
                res_q.taken <= 1'b0;
                res_q.annul <= 1'b0;
                link_q.we   <= 1'b0;
            end
        end
    end

    assign valid_o     = valid_q;
    assign npc_o       = res_q.npc;
    assign nnpc_o      = res_q.nnpc;
    assign taken_o     = res_q.taken;
    assign annul_o     = res_q.annul;
    assign target_o    = target_q;
    assign link_we_o   = link_q.we;
    assign link_idx_o  = link_q.idx;
    assign link_data_o = link_q.data;
endmodule

// File: rtl/nps_chk.sv
module nps_chk
    import nps_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [2:0]        kind_i,
    input logic              annul_in,
    input logic              pred_taken_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic [ADDR_W-1:0] npc_i,
    input logic              valid_o,
    input logic [ADDR_W-1:0] npc_o,
    input logic [ADDR_W-1:0] nnpc_o,
    input logic              taken_o,
    input logic              annul_o,
    input logic [ADDR_W-1:0] target_o,
    input logic              link_we_o,
    input logic [REG_IDXW-1:0] link_idx_o,
    input logic [ADDR_W-1:0] link_data_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && !taken_o && !annul_o && !link_we_o));

    // R2
    plain_flow_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 3'd0) |=>
            (!taken_o && !annul_o && !link_we_o && npc_o == $past(npc_i)
             && nnpc_o == $past(npc_i) + 64'd4));

    // R3
    call_link_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 3'd1) |=>
            (link_we_o && link_idx_o == 5'd15 && link_data_o == $past(pc_i)
             && taken_o && nnpc_o == target_o));

    // R6
    always_annul_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 3'd2 && annul_in) |=>
            (taken_o && annul_o && npc_o == target_o && nnpc_o == target_o + 64'd4));

    // R7
    never_untaken_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 3'd3) |=> (!taken_o && annul_o == $past(annul_in)));

    // R8
    cond_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (kind_i == 3'd4 || kind_i == 3'd5) && pred_taken_i) |=>
            (taken_o && !annul_o && nnpc_o == target_o));

    // R10
    regbr_no_annul_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && kind_i == 3'd6) |=> !annul_o);

    // R12
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!valid_o && !link_we_o));
endmodule

bind nps_seq nps_chk i_nps_chk (
    .clk          (clk),
    .rst          (rst),
    .valid_i      (valid_i),
    .kind_i       (kind_i),
    .annul_in     (inst_i[29]),
    .pred_taken_i (pred_taken_i),
    .pc_i         (pc_i),
    .npc_i        (npc_i),
    .valid_o      (valid_o),
    .npc_o        (npc_o),
    .nnpc_o       (nnpc_o),
    .taken_o      (taken_o),
    .annul_o      (annul_o),
    .target_o     (target_o),
    .link_we_o    (link_we_o),
    .link_idx_o   (link_idx_o),
    .link_data_o  (link_data_o)
);

// File: tb/test_nps_seq.sv
module test_nps_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [2:0]  kind_i;
    logic [29:0] inst_i;
    logic        pform_i, pred_taken_i;
    logic [63:0] pc_i, npc_i, rs1_val_i, rs2_val_i;
    logic        valid_o, taken_o, annul_o, link_we_o;
    logic [63:0] npc_o, nnpc_o, target_o, link_data_o;
    logic [4:0]  link_idx_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    nps_seq i_nps_seq (.*);

    typedef struct {
        logic [63:0] npc, nnpc, tgt, ldata;
        logic        taken, annul, lwe;
        logic [4:0]  lidx;
    } exp_t;

    function automatic exp_t model(logic [2:0] k, logic [29:0] w, logic pf, logic pt,
                                   logic [63:0] pc, logic [63:0] np,
                                   logic [63:0] a, logic [63:0] b);
        exp_t e;
        logic signed [63:0] s;
        logic [63:0] lo;
        logic an = w[29];
        e.npc = np; e.nnpc = np + 64'd4; e.taken = 0; e.annul = 0;
        e.lwe = 0; e.lidx = 0; e.ldata = pc;
        case (k)
            3'd1: begin s = $signed(w); e.tgt = pc + (s * 4); end
            3'd6: begin
                s = $signed(w[21:20]);
                lo = {48'd0, w[13:0], 2'b00};
                e.tgt = pc + ((s * 65536) | lo);
            end
            3'd7: begin
                s = $signed(w[12:0]);
                e.tgt = a + (w[13] ? s : b);
            end
            default: begin
                if (pf) s = $signed(w[18:0]); else s = $signed(w[21:0]);
                e.tgt = pc + (s * 4);
            end
        endcase
        case (k)
            3'd1: begin e.taken = 1; e.nnpc = e.tgt; e.lwe = 1; e.lidx = 5'd15; end
            3'd7: begin e.taken = 1; e.nnpc = e.tgt; e.lwe = 1; e.lidx = w[29:25]; end
            3'd2: begin
                e.taken = 1;
                if (an) begin e.npc = e.tgt; e.nnpc = e.tgt + 64'd4; e.annul = 1; end
                else e.nnpc = e.tgt;
            end
            3'd3: if (an) begin e.npc = np + 64'd4; e.nnpc = np + 64'd8; e.annul = 1; end
            3'd4, 3'd5: begin
                if (pt) begin e.taken = 1; e.nnpc = e.tgt; end
                else if (an) begin e.npc = np + 64'd4; e.nnpc = np + 64'd8; e.annul = 1; end
            end
            3'd6: if (pt) begin e.taken = 1; e.nnpc = e.tgt; end
            default: ;
        endcase
        return e;
    endfunction

    function automatic string tag_of(logic [2:0] k, logic pt, logic an);
        case (k)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd6: return "R10";
            3'd7: return "R11";
            default: return pt ? "R8" : (an ? "R9" : "R9");
        endcase
    endfunction

    task automatic step(string tag, logic [2:0] k, logic [29:0] w, logic pf, logic pt,
                        logic [63:0] pc, logic [63:0] np, logic [63:0] a, logic [63:0] b);
        exp_t e;
        string t;
        e = model(k, w, pf, pt, pc, np, a, b);
        t = (tag == "") ? tag_of(k, pt, w[29]) : tag;
        valid_i = 1; kind_i = k; inst_i = w; pform_i = pf; pred_taken_i = pt;
        pc_i = pc; npc_i = np; rs1_val_i = a; rs2_val_i = b;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (!valid_o || npc_o !== e.npc || nnpc_o !== e.nnpc || taken_o !== e.taken
            || annul_o !== e.annul || target_o !== e.tgt || link_we_o !== e.lwe
            || (e.lwe && (link_idx_o !== e.lidx || link_data_o !== e.ldata))) begin
            errors++;
            $display("FAIL %s kind=%0d: got npc=%h nnpc=%h tk=%b an=%b tgt=%h lwe=%b lidx=%0d ld=%h exp npc=%h nnpc=%h tk=%b an=%b tgt=%h lwe=%b lidx=%0d ld=%h",
                     t, k, npc_o, nnpc_o, taken_o, annul_o, target_o, link_we_o, link_idx_o,
                     link_data_o, e.npc, e.nnpc, e.taken, e.annul, e.tgt, e.lwe, e.lidx, e.ldata);
        end
    endtask

    function automatic logic [63:0] r64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; valid_i = 0; kind_i = 0; inst_i = 0; pform_i = 0; pred_taken_i = 0;
        pc_i = 0; npc_i = 0; rs1_val_i = 0; rs2_val_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++; // R1
        if (valid_o !== 0 || taken_o !== 0 || annul_o !== 0 || link_we_o !== 0) begin
            errors++;
            $display("FAIL R1 reset: got v=%b tk=%b an=%b lwe=%b exp 0", valid_o, taken_o, annul_o, link_we_o);
        end
        rst = 0;

        // directed corners
        step("R2", 3'd0, 30'h0, 0, 0, 64'h1000, 64'h1004, 0, 0);
        step("R3", 3'd1, 30'h2000_0000, 0, 0, 64'h4000_0000, 64'h4000_0004, 0, 0);       // most negative disp30
        step("R4", 3'd2, 30'h0020_0000, 0, 0, 64'h0100_0000, 64'h0100_0004, 0, 0);       // most negative disp22
        step("R4", 3'd4, 30'h0004_0000, 1, 1, 64'h0010_0000, 64'h0010_0004, 0, 0);       // most negative disp19
        step("R5", 3'd6, 30'h0020_0000, 0, 1, 64'h0008_0000, 64'h0008_0004, 0, 0);       // most negative high part
        step("R5", 3'd6, 30'h0010_3FFF, 0, 1, 64'h0, 64'h4, 0, 0);
        step("R6", 3'd2, 30'h2000_0010, 0, 0, 64'h2000, 64'h2004, 0, 0);
        step("R7", 3'd3, 30'h2000_0010, 0, 0, 64'h3000, 64'h3004, 0, 0);
        step("R7", 3'd3, 30'h0000_0010, 0, 0, 64'h3000, 64'h3004, 0, 0);
        step("R8", 3'd5, 30'h2000_0040, 0, 1, 64'h5000, 64'h5004, 0, 0);
        step("R9", 3'd4, 30'h2000_0040, 0, 0, 64'h5000, 64'h5004, 0, 0);
        step("R9", 3'd5, 30'h0000_0040, 0, 0, 64'h5000, 64'h5004, 0, 0);
        step("R10", 3'd6, 30'h2000_0040, 0, 0, 64'h6000, 64'h6004, 0, 0);
        step("R11", 3'd7, 30'h0E00_3000, 0, 0, 64'h7000, 64'h7004, 64'h100, 64'h5);       // simm -4096
        step("R11", 3'd7, 30'h0600_0000, 0, 0, 64'h7000, 64'h7004, 64'h100, 64'h55);      // register operand
        step("R12", 3'd2, 30'h0000_0004, 0, 0, 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0);
        step("R12", 3'd1, 30'h3FFF_FFFF, 0, 0, 64'h0, 64'h4, 0, 0);
        step("R12", 3'd3, 30'h2000_0000, 0, 0, 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0);

        // R12: dropping valid
        valid_i = 0;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (valid_o !== 0 || link_we_o !== 0) begin
            errors++;
            $display("FAIL R12 idle: got v=%b lwe=%b exp 0 0", valid_o, link_we_o);
        end

        // constrained random
        for (int n = 0; n < 600; n++) begin
            logic [63:0] pc;
            logic [63:0] np;
            pc = r64() & ~64'h3;
            np = ($urandom % 4 == 0) ? (r64() & ~64'h3) : pc + 64'd4;
            step("", 3'($urandom % 8), 30'($urandom), 1'($urandom), 1'($urandom),
                 pc, np, r64(), r64());
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule